// File: doc/BRIEF.md
# Bus Target Termination Controller

This block is the control side of a target device on a 32-bit multiplexed address/data bus with active-low handshake lines. In the cycle that opens a transaction it examines the 4-bit command, and if the command is one it serves and the back-end reports an address hit, it claims the transaction by pulling its select line low. It then paces every data phase with its ready and stop lines. With these it can end the transaction normally, refuse it before any data moves, cut a burst short with or after a transfer, or abort it on a fatal error.

The back-end is kept simple. It provides an address-hit flag, a ready flag, a "can take more" flag and a fatal-error flag. In return it gets a per-word transfer strobe and the direction of the claimed transaction. The three target lines are driven only while the block owns the bus, and a single output-enable models the tri-state pad. After the last data phase the lines are driven high for one cycle and released on the next.

Top module: `bus_target_term`

## Requirements
- R1: At an address phase (bus frame low after a cycle with it high, block idle), the block claims only if `be_hit` is 1 and the command on `cmdbe_n` is 0010, 0011, 0110, 0111, 1010 or 1011. A claim shows `claim_n`=0 and `line_oe`=1 in the cycle after the address-phase edge, with `srdy_n` and `halt_n` high. Otherwise `line_oe` stays 0.
- R2: `be_xfer` is 1 in exactly those cycles of a claimed transaction where `mrdy_n` and `srdy_n` are both 0, whether or not `halt_n` is low. `be_write` equals bit 0 of the claimed command.
- R3: With ready and "can take more" held high and no fatal error, a burst of N words ends with exactly N transfers and `halt_n` never low.
- R4: Once `srdy_n` or `halt_n` is low, none of `claim_n`, `srdy_n`, `halt_n` changes until an edge where `mrdy_n` is low.
- R5: When the back-end is not ready and cannot take more, the block asserts `halt_n` without `srdy_n` while keeping `claim_n` low. Before any transfer this is a retry with zero words; after K words it is a disconnect that moves exactly K words.
- R6: When the back-end is ready but cannot take more and the frame is still low, `srdy_n` and `halt_n` are asserted together. The transaction then moves exactly one more word.
- R7: While `halt_n` is low and the bus frame is sampled low, `halt_n` stays low at the next cycle.
- R8: A fatal error, which takes priority over ready, produces `claim_n`=1, `halt_n`=0, `srdy_n`=1. `srdy_n` is never low while `halt_n` is low and `claim_n` is high.
- R9: The cycle after the edge that completes the last data phase (frame high), all three target lines are 1 with `line_oe`=1. In the following cycle `line_oe` is 0.
- R10: Back-end flags sampled at an edge take effect in the cycle after it. The first data-phase decision is made at the edge after the address phase, so a ready back-end shows `srdy_n`=0 two cycles after the address-phase edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_n | input | 1 | Bus frame from the initiator, low while a transaction is in progress |
| mrdy_n | input | 1 | Initiator ready, low when the initiator can complete the data phase |
| cmdbe_n | input | 4 | Command in the address phase, byte enables afterwards |
| be_hit | input | 1 | Back-end address decode hit, sampled in the address phase |
| be_ready | input | 1 | Back-end can complete the next data phase |
| be_more | input | 1 | Back-end can continue the burst past the next phase |
| be_fatal | input | 1 | Back-end fatal error, requests a target abort |
| claim_n | output | 1 | Target select, low while the transaction is claimed |
| srdy_n | output | 1 | Target ready |
| halt_n | output | 1 | Target stop request |
| line_oe | output | 1 | Drive enable for the three target lines |
| be_xfer | output | 1 | A word moves at the next rising edge |
| be_write | output | 1 | Claimed transaction is a write |

## Verification
The claim appears one cycle after the address-phase edge, each reaction to the back-end flags one cycle after the edge that samples them, and the drive-high and release cycles one and two cycles after the last completing edge. The bench drives the initiator lines and back-end flags at the falling clock edge. It predicts from what it has just driven whether the coming rising edge moves a word or completes a phase. It then checks the registered target lines at the next falling edge against that prediction and against the previous cycle's values. Word counts for normal, retry, disconnect and abort endings are computed arithmetically from the limits that each sweep applies.

// File: rtl/bus_target_term.sv
module bus_target_term (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_n,
  input  logic       mrdy_n,
  input  logic [3:0] cmdbe_n,
  input  logic       be_hit,
  input  logic       be_ready,
  input  logic       be_more,
  input  logic       be_fatal,
  output logic       claim_n,
  output logic       srdy_n,
  output logic       halt_n,
  output logic       line_oe,
  output logic       be_xfer,
  output logic       be_write
);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_TURN} state_t;

  state_t state;
  logic   cyc_d, wr_q, claim_q, srdy_q, halt_q, oe_q;

  logic cmd_ok, addr_phase, committed;

  assign cmd_ok = cmdbe_n inside {4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1010, 4'b1011};
  assign addr_phase = (state == S_IDLE) && cyc_d && !cyc_n;
  assign committed  = !srdy_q || !halt_q;

  assign claim_n  = claim_q;
  assign srdy_n   = srdy_q;
  assign halt_n   = halt_q;
  assign line_oe  = oe_q;
  assign be_write = wr_q;
  assign be_xfer  = (state == S_ACT) && !mrdy_n && !srdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cyc_d   <= 1'b1;
      wr_q    <= 1'b0;
      claim_q <= 1'b1;
      srdy_q  <= 1'b1;
      halt_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      cyc_d <= cyc_n;
      case (state)
        S_IDLE: begin
          if (addr_phase && cmd_ok && be_hit) begin
            state   <= S_ACT;
            claim_q <= 1'b0;
            oe_q    <= 1'b1;
            wr_q    <= cmdbe_n[0];
          end
        end
        S_ACT: begin
          if (committed && mrdy_n) begin
            // outputs frozen until the initiator completes the phase
          end else if (committed && cyc_n) begin
            state   <= S_TURN;
            claim_q <= 1'b1;
            srdy_q  <= 1'b1;
            halt_q  <= 1'b1;
          end else if (committed && !halt_q) begin
            srdy_q <= 1'b1;
          end else if (!committed && cyc_n && mrdy_n) begin
            state   <= S_TURN;
            claim_q <= 1'b1;
          end else if (be_fatal) begin
            claim_q <= 1'b1;
            srdy_q  <= 1'b1;
            halt_q  <= 1'b0;
          end else if (be_ready) begin
            srdy_q <= 1'b0;
            halt_q <= be_more || cyc_n;
          end else if (!be_more) begin
            srdy_q <= 1'b1;
            halt_q <= 1'b0;
          end else begin
            srdy_q <= 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          oe_q  <= 1'b0;
        end
      endcase
    end
  end

  a_r1_claim_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (!claim_q && srdy_q && halt_q && $past(cyc_d && !cyc_n)));

  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT && committed && mrdy_n) |=> $stable({claim_q, srdy_q, halt_q}));

  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT && !halt_q && !cyc_n) |=> !halt_q);

  a_r8_abort_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_q && !halt_q) |-> srdy_q);

  a_r9_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TURN) |-> (claim_q && srdy_q && halt_q && oe_q));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TURN) |=> !oe_q);

  a_r2_xfer_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
    be_xfer |-> (!claim_q && oe_q));

endmodule

// File: tb/sim_bus_target_term.sv
module sim_bus_target_term;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_n = 1'b1, mrdy_n = 1'b1;
  logic [3:0] cmdbe_n = 4'h0;
  logic be_hit = 1'b0, be_ready = 1'b0, be_more = 1'b0, be_fatal = 1'b0;
  logic claim_n, srdy_n, halt_n, line_oe, be_xfer, be_write;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bus_target_term u0 (
    .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .mrdy_n(mrdy_n), .cmdbe_n(cmdbe_n),
    .be_hit(be_hit), .be_ready(be_ready), .be_more(be_more), .be_fatal(be_fatal),
    .claim_n(claim_n), .srdy_n(srdy_n), .halt_n(halt_n), .line_oe(line_oe),
    .be_xfer(be_xfer), .be_write(be_write)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [3:0] cmd, input logic hit, input int nw,
                         input int rdy_lim, input int more_lim, input int fat_lim, input int wp,
                         output int words, output bit s_stop, output bit s_abort,
                         output bit s_both, output bit s_trdy);
    bit claim_exp, fin;
    int cnt, rel, cyc;
    logic pdv, ptr, pst, pirdy, pframe, dv, tr, st, oe, mv, cp;
    claim_exp = hit && (cmd inside {4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1010, 4'b1011});
    words = 0; s_stop = 0; s_abort = 0; s_both = 0; s_trdy = 0;
    cnt = 0;
    @(negedge clk);
    cyc_n = 1'b0; cmdbe_n = cmd; be_hit = hit; mrdy_n = 1'b1;
    be_ready = (rdy_lim > 0); be_more = (more_lim > 0); be_fatal = (fat_lim <= 0);
    @(negedge clk);
    chk(claim_n == !claim_exp && line_oe == claim_exp, "R1 claim", {claim_n, line_oe}, {!claim_exp, claim_exp});
    chk(srdy_n && halt_n, "R10 no response in claim cycle", {srdy_n, halt_n}, 3);
    be_hit = 1'b0;
    if (!claim_exp) begin
      mrdy_n = 1'b0; cyc_n = 1'b1; cmdbe_n = 4'h0;
      @(negedge clk);
      chk(!line_oe, "R1 unclaimed stays off", line_oe, 0);
      mrdy_n = 1'b1;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(!line_oe && claim_n, "R1 unclaimed stays off", {line_oe, claim_n}, 1);
      end
      return;
    end
    cmdbe_n = 4'h0;
    pdv = claim_n; ptr = 1'b1; pst = 1'b1; pirdy = 1'b1; pframe = 1'b0;
    rel = 0; fin = 0;
    for (cyc = 0; cyc < 400 && !fin; cyc++) begin
      dv = claim_n; tr = srdy_n; st = halt_n; oe = line_oe;
      if (rel == 1) begin
        chk(dv && tr && st && oe, "R9 lines driven high", {dv, tr, st, oe}, 15);
        rel = 2; mrdy_n = 1'b1; cyc_n = 1'b1;
        be_ready = 1'b0; be_more = 1'b0; be_fatal = 1'b0;
      end else if (rel == 2) begin
        chk(!oe, "R9 lines released", oe, 0);
        fin = 1;
      end else begin
        if (cyc == 1) chk(tr == !(rdy_lim > 0 && fat_lim > 0), "R10 first decision", tr, !(rdy_lim > 0 && fat_lim > 0));
        if ((!ptr || !pst) && pirdy)
          chk({dv, tr, st} == {pdv, ptr, pst}, "R4 frozen while initiator waits", {dv, tr, st}, {pdv, ptr, pst});
        if (!pst && !pframe) chk(!st, "R7 halt held while frame low", st, 0);
        if (!st && dv) chk(tr, "R8 abort without ready", tr, 1);
        if (!st) s_stop = 1;
        if (!st && dv) s_abort = 1;
        if (!st && !tr && !dv) s_both = 1;
        if (!tr) s_trdy = 1;
        if (cyc_n) mrdy_n = 1'b0;
        else mrdy_n = (wp != 0) && (cyc % wp == 1);
        if (!cyc_n && !mrdy_n && ((nw - cnt) <= 1 || !st)) cyc_n = 1'b1;
        mv = !mrdy_n && !tr;
        cp = !mrdy_n && (!tr || !st);
        #1;
        chk(be_xfer == mv, "R2 transfer strobe", be_xfer, mv);
        if (mv) begin
          chk(be_write == cmd[0], "R2 direction", be_write, cmd[0]);
          cnt++;
        end
        if (cp && cyc_n) rel = 1;
        be_ready = cnt < rdy_lim;
        be_more  = cnt < more_lim;
        be_fatal = cnt >= fat_lim;
        pdv = dv; ptr = tr; pst = st; pirdy = mrdy_n; pframe = cyc_n;
      end
      if (!fin) @(negedge clk);
    end
    chk(fin, "R9 transaction finished", fin, 1);
    cyc_n = 1'b1; mrdy_n = 1'b1;
    words = cnt;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w;
    bit ss, sa, sb, sr;
    repeat (3) @(negedge clk);
    chk(claim_n && srdy_n && halt_n && !line_oe && !be_xfer, "R1 reset state",
        {claim_n, srdy_n, halt_n, line_oe, be_xfer}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 16; c++) begin
      for (int h = 0; h < 2; h++) begin
        bit ok;
        ok = (h == 1) && (c == 2 || c == 3 || c == 6 || c == 7 || c == 10 || c == 11);
        run_txn(4'(c), 1'(h), 1, 1000, 1000, 1000, 0, w, ss, sa, sb, sr);
        chk(w == (ok ? 1 : 0), "R1 single word per claimed command", w, ok ? 1 : 0);
      end
    end

    for (int wp = 0; wp < 4; wp += 3) begin
      for (int n = 1; n <= 6; n++) begin
        run_txn(4'b0111, 1'b1, n, 1000, 1000, 1000, wp, w, ss, sa, sb, sr);
        chk(w == n && !ss, "R3 normal burst", w, n);
      end

      run_txn(4'b0110, 1'b1, 4, 0, 0, 1000, wp, w, ss, sa, sb, sr);
      chk(w == 0 && ss && !sa && !sr, "R5 retry", w, 0);

      for (int k = 1; k <= 3; k++) begin
        run_txn(4'b0011, 1'b1, 6, k, k, 1000, wp, w, ss, sa, sb, sr);
        chk(w == k && ss && !sa && !sb, "R5 disconnect without data", w, k);
      end

      for (int k = 1; k <= 4; k++) begin
        run_txn(4'b0111, 1'b1, 6, 1000, k - 1, 1000, wp, w, ss, sa, sb, sr);
        chk(w == k && sb && !sa, "R6 disconnect with data", w, k);
      end

      for (int f = 0; f <= 3; f++) begin
        run_txn(4'b1011, 1'b1, 6, 1000, 1000, f, wp, w, ss, sa, sb, sr);
        chk(w == f && sa && !sb, "R8 target abort", w, f);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule